// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sequences the low-power modes of a small 8-bit microcontroller core. Software writes a four-bit power control register that holds an idle request, a power-down request and two general-purpose flag bits. From the register and from a set of wake inputs, the block drives three clock enables: one for the oscillator, one for the CPU clock and one for the peripheral clock. While the CPU is halted, it also holds the address-latch and program-store strobes high and keeps the port outputs frozen.

In idle the oscillator and the peripheral clock keep running, and any enabled interrupt brings the core back. Power-down stops the oscillator. The external interrupt pins, which are active low, wake the core in two phases: a low level restarts the oscillator, and a release completes the exit. The keyboard, card-detect and USB requests instead restart the oscillator and wait out a fixed settle count before the CPU clock is enabled again. A hardware reset is accepted only after it has been held for a minimum number of clocks.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: When `rstIn` is high on 24 consecutive rising clock edges, the 24th such edge returns the block to running mode. At that point `modeOut`=0, `pconOut`=0 and `oscEn`=`cpuClkEn`=`periphClkEn`=1, and this holds for as long as `rstIn` stays high. The `modeOut` encoding is 0 run, 1 idle, 2 power-down, 3 pin-wake phase and 4 settle phase.
- R2: A high pulse on `rstIn` that spans fewer than 24 rising edges is ignored. Mode and register contents are unchanged.
- R3: A write in running mode with `wrData` bit 0 set and bit 1 clear enters idle after that edge. Idle gives `modeOut`=1, `pconOut` bit 0 = 1, `cpuClkEn`=0, `periphClkEn`=1 and `oscEn`=1.
- R4: Whenever the mode is not running, `aleOut` and `psenOut` are 1. In the same modes, `portOut` holds the `portIn` value sampled on the write that left running mode. In running mode the three outputs follow `aleCpu`, `psenCpu` and `portIn`.
- R5: In idle, `intPend` high returns the block to running mode after that edge. Bit 0 of `pconOut` is cleared, and flag bits 3:2 keep their value.
- R6: A write in running mode with `wrData` bit 1 set enters power-down, in which all three clock enables are 0 and `modeOut`=2. If bits 0 and 1 are both set, power-down wins and `pconOut` reads bit 1 = 1, bit 0 = 0.
- R7: In power-down, an enabled external pin at a low level moves the block, after that edge, to the pin-wake phase. The pin-wake phase gives `modeOut`=3, `oscEn`=1, `cpuClkEn`=0 and `periphClkEn`=0. Pin 0 is enabled by `extEn` bit 0 and pin 1 by bit 1. Low levels on disabled pins have no effect, and neither does `intPend`.
- R8: In the pin-wake phase, a pin that was enabled and low on the previous edge and is high on the current edge ends power-down after that edge, even while the other pin stays low. The exit gives running mode, clears `pconOut` bits 1:0 and keeps the flags.
- R9: In power-down with no enabled pin low, a keyboard, card or USB wake request enters the settle phase after that edge, with `modeOut`=4, `oscEn`=1 and `cpuClkEn`=0. Running mode returns exactly 1024 rising edges after the edge that took the request.
- R10: Flag bits 3:2 of `pconOut` take `wrData` bits 3:2 on a write in running mode and keep their value through idle and power-down. Writes made in any other mode are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rstIn | input | 1 | Hardware reset request, active high, qualified by hold length |
| wrEn | input | 1 | Power control register write strobe |
| wrData | input | 4 | Write data: bit 0 idle, bit 1 power-down, bits 3:2 flags |
| intPend | input | 1 | An enabled interrupt is pending |
| ext0N | input | 1 | External interrupt pin 0, active low |
| ext1N | input | 1 | External interrupt pin 1, active low |
| extEn | input | 2 | Per-pin wake enable for the external pins |
| kbdWake | input | 1 | Keyboard wake request |
| cardWake | input | 1 | Card insertion or removal wake request |
| usbWake | input | 1 | USB wake request |
| aleCpu | input | 1 | Address-latch strobe from the CPU |
| psenCpu | input | 1 | Program-store strobe from the CPU |
| portIn | input | 8 | Port values from the CPU |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| aleOut | output | 1 | Address-latch strobe to the pins |
| psenOut | output | 1 | Program-store strobe to the pins |
| portOut | output | 8 | Port values to the pins |
| pconOut | output | 4 | Power control register contents |
| modeOut | output | 3 | Current mode code |

## Verification
The assertions assume a few things about the inputs:
- The first event is a hardware reset held long enough to be accepted. Until that reset is seen, all checks are disarmed.
- `wrEn` is treated as meaningful only in running mode.
- Each wake request is sampled as a level on a clock edge.

The stimulus keeps within these rules. It holds `rstIn` for 30 edges before any other activity. It drives every input just after a falling edge, so each level is stable at the next rising edge. It releases a wake pin only after the pin-wake phase has been observed. The short-reset test ends its pulse after 23 edges, one below the acceptance count.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_IDLE      = 3'd1,
    ST_PD        = 3'd2,
    ST_PD_PIN    = 3'd3,
    ST_PD_SETTLE = 3'd4
  } pmState_t;

  // Strobes from the control sequencer to the datapath
  typedef struct packed {
    logic wrAccept;   // load the control register from wrData
    logic clrModes;   // hardware clear of both mode bits
    logic holdPort;   // capture port values on entry to a halted mode
    logic settleClr;  // restart the oscillator settle count
    logic settleRun;  // advance the settle count
  } pmCtl_t;

endpackage

// File: rtl/pwrmode_dp.sv
module pwrmode_dp
  import pwrmode_pkg::*;
#(
  parameter int PORT_W        = 8,
  parameter int NUM_EXT       = 2,
  parameter int SETTLE_CYCLES = 1024,
  parameter int RST_HOLD      = 24
) (
  input  logic              clk,
  input  logic              rstIn,
  input  pmCtl_t            ctl,
  input  logic [3:0]        wrData,
  input  logic [NUM_EXT-1:0] extPinN,
  input  logic [NUM_EXT-1:0] extEn,
  input  logic              kbdWake,
  input  logic              cardWake,
  input  logic              usbWake,
  input  logic [PORT_W-1:0] portIn,
  output logic              rstAct,
  output logic              pinLowAny,
  output logic              pinRelease,
  output logic              settleWake,
  output logic              settleDone,
  output logic [3:0]        pconQ,
  output logic [PORT_W-1:0] portHeld
);

  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam int RC_W  = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [RC_W-1:0]  RST_LAST    = RC_W'(RST_HOLD - 1);

  logic [RC_W-1:0]    rstCnt;
  logic [CNT_W-1:0]   settleCnt;
  logic [NUM_EXT-1:0] pinLow;
  logic [NUM_EXT-1:0] prevLowQ;
  logic [NUM_EXT-1:0] pinRel;

  // Reset length qualifier: counts consecutive high samples, saturating
  always_ff @(posedge clk) begin
    if (!rstIn)               rstCnt <= '0;
    else if (rstCnt != RST_LAST) rstCnt <= rstCnt + 1'b1;
  end
  assign rstAct = rstIn && (rstCnt == RST_LAST);

  // Per-pin low detection and release against the previous edge
  for (genvar p = 0; p < NUM_EXT; p++) begin : g_pin
    assign pinLow[p] = extEn[p] & ~extPinN[p];
    assign pinRel[p] = prevLowQ[p] & ~pinLow[p];
  end

  always_ff @(posedge clk) begin
    if (rstAct) prevLowQ <= '0;
    else        prevLowQ <= pinLow;
  end

  assign pinLowAny  = |pinLow;
  assign pinRelease = |pinRel;
  assign settleWake = kbdWake | cardWake | usbWake;

  // Oscillator settle counter
  always_ff @(posedge clk) begin
    if (rstAct || ctl.settleClr) settleCnt <= '0;
    else if (ctl.settleRun)      settleCnt <= settleCnt + 1'b1;
  end
  assign settleDone = (settleCnt == SETTLE_LAST);

  // Power control register: [3:2] flags, [1] power-down, [0] idle
  always_ff @(posedge clk) begin
    if (rstAct)            pconQ <= '0;
    else if (ctl.wrAccept) pconQ <= {wrData[3:2], wrData[1], wrData[0] & ~wrData[1]};
    else if (ctl.clrModes) pconQ[1:0] <= 2'b00;
  end

  // Port snapshot taken when the CPU stops
  always_ff @(posedge clk) begin
    if (rstAct)            portHeld <= '0;
    else if (ctl.holdPort) portHeld <= portIn;
  end

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
(
  input  logic     clk,
  input  logic     rstAct,
  input  logic     wrEn,
  input  logic     wrIdle,
  input  logic     wrPd,
  input  logic     intPend,
  input  logic     pinLowAny,
  input  logic     pinRelease,
  input  logic     settleWake,
  input  logic     settleDone,
  output pmState_t state,
  output pmCtl_t   ctl
);

  pmState_t stateD;

  always_ff @(posedge clk) begin
    if (rstAct) state <= ST_RUN;
    else        state <= stateD;
  end

  always_comb begin
    stateD = state;
    ctl    = '0;
    unique case (state)
      ST_RUN: begin
        if (wrEn) begin
          ctl.wrAccept = 1'b1;
          if (wrPd) begin
            stateD       = ST_PD;
            ctl.holdPort = 1'b1;
          end else if (wrIdle) begin
            stateD       = ST_IDLE;
            ctl.holdPort = 1'b1;
          end
        end
      end
      ST_IDLE: begin
        if (intPend) begin
          stateD       = ST_RUN;
          ctl.clrModes = 1'b1;
        end
      end
      ST_PD: begin
        if (pinLowAny) begin
          stateD = ST_PD_PIN;
        end else if (settleWake) begin
          stateD        = ST_PD_SETTLE;
          ctl.settleClr = 1'b1;
        end
      end
      ST_PD_PIN: begin
        if (pinRelease) begin
          stateD       = ST_RUN;
          ctl.clrModes = 1'b1;
        end
      end
      ST_PD_SETTLE: begin
        ctl.settleRun = 1'b1;
        if (settleDone) begin
          stateD       = ST_RUN;
          ctl.clrModes = 1'b1;
        end
      end
      default: stateD = ST_RUN;
    endcase
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int PORT_W        = 8,
  parameter int SETTLE_CYCLES = 1024,
  parameter int RST_HOLD      = 24
) (
  input  logic              clk,
  input  logic              rstIn,
  input  logic              wrEn,
  input  logic [3:0]        wrData,
  input  logic              intPend,
  input  logic              ext0N,
  input  logic              ext1N,
  input  logic [1:0]        extEn,
  input  logic              kbdWake,
  input  logic              cardWake,
  input  logic              usbWake,
  input  logic              aleCpu,
  input  logic              psenCpu,
  input  logic [PORT_W-1:0] portIn,
  output logic              oscEn,
  output logic              cpuClkEn,
  output logic              periphClkEn,
  output logic              aleOut,
  output logic              psenOut,
  output logic [PORT_W-1:0] portOut,
  output logic [3:0]        pconOut,
  output logic [2:0]        modeOut
);

  pmState_t          state;
  pmCtl_t            ctl;
  logic              rstAct;
  logic              pinLowAny;
  logic              pinRelease;
  logic              settleWake;
  logic              settleDone;
  logic [3:0]        pconQ;
  logic [PORT_W-1:0] portHeld;

  pwrmode_ctrl ctrl_i (
    .clk        (clk),
    .rstAct     (rstAct),
    .wrEn       (wrEn),
    .wrIdle     (wrData[0]),
    .wrPd       (wrData[1]),
    .intPend    (intPend),
    .pinLowAny  (pinLowAny),
    .pinRelease (pinRelease),
    .settleWake (settleWake),
    .settleDone (settleDone),
    .state      (state),
    .ctl        (ctl)
  );

  pwrmode_dp #(
    .PORT_W        (PORT_W),
    .NUM_EXT       (2),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .RST_HOLD      (RST_HOLD)
  ) dp_i (
    .clk        (clk),
    .rstIn      (rstIn),
    .ctl        (ctl),
    .wrData     (wrData),
    .extPinN    ({ext1N, ext0N}),
    .extEn      (extEn),
    .kbdWake    (kbdWake),
    .cardWake   (cardWake),
    .usbWake    (usbWake),
    .portIn     (portIn),
    .rstAct     (rstAct),
    .pinLowAny  (pinLowAny),
    .pinRelease (pinRelease),
    .settleWake (settleWake),
    .settleDone (settleDone),
    .pconQ      (pconQ),
    .portHeld   (portHeld)
  );

  always_comb begin
    oscEn       = 1'b1;
    cpuClkEn    = 1'b1;
    periphClkEn = 1'b1;
    unique case (state)
      ST_RUN:       ;
      ST_IDLE:      cpuClkEn = 1'b0;
      ST_PD:        {oscEn, cpuClkEn, periphClkEn} = 3'b000;
      ST_PD_PIN,
      ST_PD_SETTLE: {cpuClkEn, periphClkEn} = 2'b00;
      default:      ;
    endcase
  end

  assign aleOut  = (state == ST_RUN) ? aleCpu  : 1'b1;
  assign psenOut = (state == ST_RUN) ? psenCpu : 1'b1;
  assign portOut = (state == ST_RUN) ? portIn  : portHeld;
  assign pconOut = pconQ;
  assign modeOut = state;

endmodule

// File: rtl/pwrmode_chk.sv
module pwrmode_chk
  import pwrmode_pkg::*;
#(
  parameter int PORT_W        = 8,
  parameter int SETTLE_CYCLES = 1024,
  parameter int RST_HOLD      = 24
) (
  input logic              clk,
  input logic              rstIn,
  input logic              wrEn,
  input logic [3:0]        wrData,
  input logic              intPend,
  input logic              oscEn,
  input logic              cpuClkEn,
  input logic              periphClkEn,
  input logic              aleOut,
  input logic              psenOut,
  input logic [PORT_W-1:0] portOut,
  input logic [3:0]        pconOut,
  input logic [2:0]        modeOut
);

  localparam int RW = $clog2(RST_HOLD) + 1;
  localparam int SW = $clog2(SETTLE_CYCLES) + 1;

  logic          armedQ = 1'b0;
  logic [RW-1:0] chkRst = '0;
  logic [SW-1:0] chkSet = '0;

  always_ff @(posedge clk) begin
    if (!rstIn)                         chkRst <= '0;
    else if (chkRst != RW'(RST_HOLD-1)) chkRst <= chkRst + 1'b1;
    if (rstIn && chkRst == RW'(RST_HOLD-1)) armedQ <= 1'b1;
    chkSet <= (modeOut == ST_PD_SETTLE) ? chkSet + 1'b1 : '0;
  end

  AST_RESET_RUN: assert property (@(posedge clk) disable iff (!armedQ)
    (rstIn && chkRst == RW'(RST_HOLD-1)) |=> (modeOut == ST_RUN && pconOut == 4'h0 && oscEn && cpuClkEn && periphClkEn)); // R1
  AST_SHORT_RESET: assert property (@(posedge clk) disable iff (!armedQ)
    (rstIn && chkRst < RW'(RST_HOLD-1) && modeOut == ST_IDLE && !intPend) |=> (modeOut == ST_IDLE)); // R2
  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rstIn || !armedQ)
    (modeOut == ST_RUN && wrEn && wrData[0] && !wrData[1]) |=> (!cpuClkEn && periphClkEn && oscEn)); // R3
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rstIn || !armedQ)
    !cpuClkEn |-> (aleOut && psenOut)); // R4
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (rstIn || !armedQ)
    (!cpuClkEn && $past(!cpuClkEn)) |-> $stable(portOut)); // R4
  AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (rstIn || !armedQ)
    (modeOut == ST_IDLE && intPend) |=> (modeOut == ST_RUN && cpuClkEn && !pconOut[0])); // R5
  AST_PD_ENTRY: assert property (@(posedge clk) disable iff (rstIn || !armedQ)
    (modeOut == ST_RUN && wrEn && wrData[1]) |=> (!oscEn && !cpuClkEn && !periphClkEn && pconOut[1:0] == 2'b10)); // R6
  AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (rstIn || !armedQ)
    ($past(modeOut) == ST_PD_SETTLE && modeOut == ST_RUN) |-> ($past(chkSet) == SW'(SETTLE_CYCLES-1))); // R9
  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rstIn || !armedQ)
    (!cpuClkEn && $past(!cpuClkEn)) |-> $stable(pconOut[3:2])); // R10

endmodule

bind pwr_mode_ctrl pwrmode_chk #(
  .PORT_W        (PORT_W),
  .SETTLE_CYCLES (SETTLE_CYCLES),
  .RST_HOLD      (RST_HOLD)
) chk_i (
  .clk         (clk),
  .rstIn       (rstIn),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .intPend     (intPend),
  .oscEn       (oscEn),
  .cpuClkEn    (cpuClkEn),
  .periphClkEn (periphClkEn),
  .aleOut      (aleOut),
  .psenOut     (psenOut),
  .portOut     (portOut),
  .pconOut     (pconOut),
  .modeOut     (modeOut)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;

  typedef struct packed {
    logic [3:0] wr;
    logic [2:0] mode;
    logic [2:0] en;    // {osc, cpu, periph}
    logic [3:0] pcon;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{4'h1, 3'd1, 3'b101, 4'h1},
    '{4'h2, 3'd2, 3'b000, 4'h2},
    '{4'h3, 3'd2, 3'b000, 4'h2},
    '{4'h5, 3'd1, 3'b101, 4'h5},
    '{4'hE, 3'd2, 3'b000, 4'hE},
    '{4'h8, 3'd0, 3'b111, 4'h8}
  };

  logic       clk = 1'b0;
  logic       rstIn = 1'b0, wrEn = 1'b0, intPend = 1'b0;
  logic [3:0] wrData = 4'h0;
  logic       ext0N = 1'b1, ext1N = 1'b1;
  logic [1:0] extEn = 2'b00;
  logic       kbdWake = 1'b0, cardWake = 1'b0, usbWake = 1'b0;
  logic       aleCpu = 1'b0, psenCpu = 1'b0;
  logic [7:0] portIn = 8'h00;
  logic       oscEn, cpuClkEn, periphClkEn, aleOut, psenOut;
  logic [7:0] portOut;
  logic [3:0] pconOut;
  logic [2:0] modeOut;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk(clk), .rstIn(rstIn), .wrEn(wrEn), .wrData(wrData), .intPend(intPend),
    .ext0N(ext0N), .ext1N(ext1N), .extEn(extEn), .kbdWake(kbdWake),
    .cardWake(cardWake), .usbWake(usbWake), .aleCpu(aleCpu), .psenCpu(psenCpu),
    .portIn(portIn), .oscEn(oscEn), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
    .aleOut(aleOut), .psenOut(psenOut), .portOut(portOut), .pconOut(pconOut),
    .modeOut(modeOut)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write(logic [3:0] d);
    wrEn = 1'b1; wrData = d;
    tick();
    wrEn = 1'b0; wrData = 4'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick();
    rstIn = 1'b1;
    tick(30);
    check("R1 mode while held", modeOut, 0);
    rstIn = 1'b0;
    tick();
    check("R1 mode", modeOut, 0);
    check("R1 pcon", pconOut, 0);
    check("R1 enables", {oscEn, cpuClkEn, periphClkEn}, 3'b111);

    // Table walk: write from run, check mode, then return to run
    for (int i = 0; i < NVEC; i++) begin
      write(VEC[i].wr);
      check("R3/R6 mode", modeOut, VEC[i].mode);
      check("R3/R6 enables", {oscEn, cpuClkEn, periphClkEn}, VEC[i].en);
      check("R6/R10 pcon", pconOut, VEC[i].pcon);
      if (VEC[i].mode == 3'd1) begin
        intPend = 1'b1; tick(); intPend = 1'b0;
        check("R5 idle exit mode", modeOut, 0);
        check("R5 flags kept", pconOut, {VEC[i].pcon[3:2], 2'b00});
      end else if (VEC[i].mode == 3'd2) begin
        extEn = 2'b01; ext0N = 1'b0; tick();
        check("R7 pin phase mode", modeOut, 3);
        check("R7 pin phase enables", {oscEn, cpuClkEn, periphClkEn}, 3'b100);
        ext0N = 1'b1; tick(); extEn = 2'b00;
        check("R8 release exit mode", modeOut, 0);
        check("R8 flags kept", pconOut, {VEC[i].pcon[3:2], 2'b00});
      end
    end

    // Strobe and port hold across idle
    aleCpu = 1'b0; psenCpu = 1'b0; portIn = 8'h5A;
    tick();
    check("R4 run port follows", portOut, 8'h5A);
    check("R4 run strobes follow", {aleOut, psenOut}, 2'b00);
    write(4'h5);
    portIn = 8'hC3;
    tick();
    check("R4 port held", portOut, 8'h5A);
    check("R4 strobes high", {aleOut, psenOut}, 2'b11);
    // Write while idle is ignored
    write(4'h8);
    check("R10 idle write ignored pcon", pconOut, 4'h5);
    check("R10 idle write ignored mode", modeOut, 1);

    // Short reset in idle is ignored
    rstIn = 1'b1; tick(23); rstIn = 1'b0; tick();
    check("R2 short reset mode", modeOut, 1);
    check("R2 short reset pcon", pconOut, 4'h5);
    // Long reset in idle is accepted on the 24th edge
    rstIn = 1'b1; tick(24);
    check("R1 reset from idle mode", modeOut, 0);
    check("R1 reset from idle pcon", pconOut, 0);
    rstIn = 1'b0; tick();

    // Disabled pin and interrupt ignored in power-down
    write(4'h2);
    extEn = 2'b01; ext1N = 1'b0; intPend = 1'b1; tick(2);
    check("R7 disabled pin ignored", modeOut, 2);
    check("R7 osc stays off", oscEn, 0);
    intPend = 1'b0;
    // Both pins enabled: first release completes exit
    extEn = 2'b11; ext0N = 1'b0; tick();
    check("R7 both low pin phase", modeOut, 3);
    ext0N = 1'b1; tick();
    check("R8 first release exit", modeOut, 0);
    ext1N = 1'b1; extEn = 2'b00; tick();

    // Keyboard wake: 1024 edges of settling
    write(4'h2);
    kbdWake = 1'b1; tick(); kbdWake = 1'b0;
    check("R9 settle mode", modeOut, 4);
    check("R9 settle enables", {oscEn, cpuClkEn, periphClkEn}, 3'b100);
    tick(1023);
    check("R9 still settling at 1023", cpuClkEn, 0);
    tick();
    check("R9 run after 1024", modeOut, 0);
    check("R9 cpu clock on", cpuClkEn, 1);

    // USB wake behaves the same
    write(4'h2);
    usbWake = 1'b1; tick(); usbWake = 1'b0;
    check("R9 usb settle mode", modeOut, 4);
    tick(1024);
    check("R9 usb run after 1024", modeOut, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule